// File: doc/BRIEF.md
# Guarded Flash Write Controller

This block sits between a CPU's byte-wide register bus and the control side of a non-volatile memory. Software selects a target space and a 22-bit address through a set of small registers. A write to the memory can be launched only after a fixed unlock ritual. Software first writes two key bytes, one after the other, to a register that stores nothing. It must then set the write-start bit in the control register, with write-enable already on. Any other bus access in between cancels the ritual.

While a write to program or configuration space is running, the block holds the CPU in a stall. The memory is modelled as a start pulse and a done input. When the memory reports done, the write-start bit clears itself and a one-cycle completion flag is raised. Two reset inputs are provided. If a warm reset (master clear or watchdog) cuts a write short, an error bit is set, and that bit survives every warm reset until software clears it. A power-on reset clears everything.

Top module: `nvm_write_guard`

## Requirements
- R1: The key register (address 1) holds no data. It always reads 0x00, and writing it changes no readable register.
- R2: A write starts only after three bus accesses in a row: 0x55 written to address 1, then 0xAA written to address 1, then a control write (address 0) with bit 1 (WR) set. `nvm_start` is high for exactly the one cycle after that control write.
- R3: Any bus access that is not the next expected step cancels the unlock sequence. This includes a wrong key value, a key pair in the wrong order, a write or read of another address, and a WR=0 control write. A later WR write then starts nothing.
- R4: WR starts a write only if bit 0 (WREN) of the control register was already 1 before the control write that sets WR. Setting WREN and WR in the same write starts nothing.
- R5: WR reads back as 1 while a write is busy, and clears when `nvm_done` is seen. A software write of WR=0 while busy does not clear it.
- R6: `cpu_stall` is high while a write to program or configuration space is busy. It stays low for a write to data space.
- R7: A warm reset (`warm_rst_n` low at a clock edge) during a busy write sets bit 3 (ERR). ERR survives warm resets and is cleared by `por_n`. A control write with bit 3 = 0 clears it, and writing bit 3 = 1 never sets it.
- R8: A warm reset clears WREN, WR, bit 4 (CFG), bit 5 (PGM) and the address pointer, and abandons any partial unlock.
- R9: `nvm_sel` picks the target space. It is 2'b10 (configuration) when CFG is 1 or pointer bit 21 is 1. Otherwise it is 2'b01 (program) when PGM is 1, and otherwise 2'b00 (data).
- R10: `done_irq` is high for exactly one cycle after a write ends through `nvm_done`. It is not raised when a warm reset aborts a write, or when `nvm_done` arrives with no write busy.
- R11: The pointer is written as bytes. Address 2 holds bits 7:0, address 3 holds bits 15:8, and address 4 holds bits 21:16, with the upper two bits of the byte reading 0. `nvm_addr` carries the whole pointer.
- R12: Writing bit 2 (RD) of the control register while idle gives a one-cycle `nvm_rd_start` pulse and needs no unlock. Addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low, clears everything |
| warm_rst_n | input | 1 | Master-clear or watchdog reset, synchronous, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| nvm_start | output | 1 | One-cycle write launch to the memory |
| nvm_rd_start | output | 1 | One-cycle read launch to the memory |
| nvm_sel | output | 2 | Target space: 00 data, 01 program, 10 configuration |
| nvm_addr | output | 22 | Address pointer |
| nvm_done | input | 1 | Memory reports that the write has finished |
| cpu_stall | output | 1 | Holds the CPU during a program or configuration write |
| done_irq | output | 1 | One-cycle flag on normal completion |

## Verification
The unlock ritual is tried with several patterns: the correct triple, the keys swapped, the first key repeated, a pointer write slipped between the keys, a third key write in place of WR, a WR=0 final step, a control write placed before the keys, and a read slipped between the keys. Only the correct triple may produce a start pulse, so the other patterns show that order and contiguity both matter. Writes to data, program and configuration space show which targets stall the CPU. A warm reset in the middle of a write is set against a normal completion to separate the error path from the completion flag. A second warm reset, and then a power-on reset, show which of the two can clear the error.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_KEY  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PLO  = 3'd2;

    // control register bit positions
    localparam int B_WEN = 0;
    localparam int B_GO  = 1;
    localparam int B_RD  = 2;
    localparam int B_ERR = 3;
    localparam int B_CFG = 4;
    localparam int B_PGM = 5;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_HALF  = 2'd1,
        SQ_ARMED = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        RG_DATA = 2'b00,
        RG_PROG = 2'b01,
        RG_CONF = 2'b10
    } region_e;
endpackage

// File: rtl/nvm_unlock_seq.sv
module nvm_unlock_seq
    import nvm_guard_pkg::*;
#(
    parameter logic [BUS_W-1:0] KEY_A = 8'h55,
    parameter logic [BUS_W-1:0] KEY_B = 8'hAA
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic              armed
);
    typedef struct packed {
        seq_e st;
    } seq_s;

    seq_s seq_d, seq_q;
    logic key_wr;

    always_comb begin
        seq_d  = seq_q;
        key_wr = bus_sel && bus_we && (bus_addr == A_KEY);
        if (!warm_rst_n) begin
            seq_d.st = SQ_IDLE;
        end else if (bus_sel) begin
            if (key_wr && bus_wdata == KEY_A)
                seq_d.st = SQ_HALF;
            else if (key_wr && bus_wdata == KEY_B && seq_q.st == SQ_HALF)
                seq_d.st = SQ_ARMED;
            else
                seq_d.st = SQ_IDLE;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign armed = (seq_q.st == SQ_ARMED);

    // R2: arming only follows the second key written in the prior cycle
    p_arm_after_key_b_r2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(armed) |-> $past(bus_sel && bus_we && bus_addr == A_KEY && bus_wdata == KEY_B));

    // R3: any access while armed consumes or cancels the arming
    p_arm_one_shot_r3: assert property (@(posedge clk) disable iff (!por_n)
        armed && bus_sel |=> !armed);

    // R8: warm reset abandons the sequence
    p_seq_warm_clear_r8: assert property (@(posedge clk) disable iff (!por_n)
        !warm_rst_n |=> seq_q.st == SQ_IDLE);
endmodule

// File: rtl/nvm_tblptr.sv
module nvm_tblptr
    import nvm_guard_pkg::*;
#(
    parameter int PTR_W = 22
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  rd_byte,
    output logic [PTR_W-1:0]  ptr
);
    localparam int NLANE = (PTR_W + BUS_W - 1) / BUS_W;
    localparam int WIDE  = NLANE * BUS_W;

    typedef struct packed {
        logic [PTR_W-1:0] val;
    } ptr_s;

    ptr_s ptr_d, ptr_q;
    logic [NLANE-1:0] lane_hit;
    logic [WIDE-1:0]  wide_q;
    logic [WIDE-1:0]  wide_n;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_hit[g] = bus_addr == ADDR_W'(int'(A_PLO) + g);
    end

    always_comb begin
        wide_q              = '0;
        wide_q[PTR_W-1:0]   = ptr_q.val;
        wide_n              = wide_q;
        for (int i = 0; i < NLANE; i++) begin
            if (bus_sel && bus_we && lane_hit[i])
                wide_n[i*BUS_W +: BUS_W] = bus_wdata;
        end
        ptr_d.val = warm_rst_n ? wide_n[PTR_W-1:0] : '0;
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NLANE; i++) begin
            if (lane_hit[i]) rd_byte = wide_q[i*BUS_W +: BUS_W];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q.val;

    // R11: pointer moves only on a bus write or a warm reset
    p_ptr_hold_r11: assert property (@(posedge clk) disable iff (!por_n)
        !(bus_sel && bus_we) && warm_rst_n |=> $stable(ptr));
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
    import nvm_guard_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              armed,
    input  logic              ptr_conf,
    input  logic              nvm_done,
    output logic [BUS_W-1:0]  ctrl_byte,
    output logic              nvm_start,
    output logic              nvm_rd_start,
    output logic [1:0]        nvm_sel,
    output logic              cpu_stall,
    output logic              done_irq
);
    typedef struct packed {
        logic    wen;
        logic    go;
        logic    cfg;
        logic    pgm;
        logic    err;
        logic    start;
        logic    rdp;
        logic    irq;
        region_e busy_rg;
    } ctl_s;

    ctl_s    ctl_d, ctl_q;
    region_e live_rg;
    logic    ctrl_wr;
    logic    unused_hi;

    assign unused_hi = ^bus_wdata[BUS_W-1:B_PGM+1];

    always_comb begin
        if (ctl_q.cfg || ptr_conf) live_rg = RG_CONF;
        else if (ctl_q.pgm)        live_rg = RG_PROG;
        else                       live_rg = RG_DATA;
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        ctl_d.rdp   = 1'b0;
        ctl_d.irq   = 1'b0;
        ctrl_wr     = bus_sel && bus_we && (bus_addr == A_CTRL);
        if (!warm_rst_n) begin
            ctl_d.wen     = 1'b0;
            ctl_d.go      = 1'b0;
            ctl_d.cfg     = 1'b0;
            ctl_d.pgm     = 1'b0;
            ctl_d.busy_rg = RG_DATA;
            ctl_d.err     = ctl_q.err | ctl_q.go;
        end else begin
            if (ctl_q.go && nvm_done) begin
                ctl_d.go  = 1'b0;
                ctl_d.irq = 1'b1;
            end
            if (ctrl_wr) begin
                ctl_d.wen = bus_wdata[B_WEN];
                ctl_d.cfg = bus_wdata[B_CFG];
                ctl_d.pgm = bus_wdata[B_PGM];
                ctl_d.err = ctl_q.err & bus_wdata[B_ERR];
                if (bus_wdata[B_GO] && armed && ctl_q.wen && !ctl_q.go) begin
                    ctl_d.go      = 1'b1;
                    ctl_d.start   = 1'b1;
                    ctl_d.busy_rg = live_rg;
                end
                if (bus_wdata[B_RD] && !ctl_q.go)
                    ctl_d.rdp = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        ctrl_byte        = '0;
        ctrl_byte[B_WEN] = ctl_q.wen;
        ctrl_byte[B_GO]  = ctl_q.go;
        ctrl_byte[B_RD]  = ctl_q.rdp;
        ctrl_byte[B_ERR] = ctl_q.err;
        ctrl_byte[B_CFG] = ctl_q.cfg;
        ctrl_byte[B_PGM] = ctl_q.pgm;
    end

    assign nvm_start    = ctl_q.start;
    assign nvm_rd_start = ctl_q.rdp;
    assign nvm_sel      = live_rg;
    assign cpu_stall    = ctl_q.go && (ctl_q.busy_rg != RG_DATA);
    assign done_irq     = ctl_q.irq;

    // R2: a launch needs the sequencer armed on the launching write
    p_start_needs_arm_r2: assert property (@(posedge clk) disable iff (!por_n)
        nvm_start |-> $past(armed));

    // R4: a launch needs write-enable already set
    p_start_needs_wen_r4: assert property (@(posedge clk) disable iff (!por_n)
        nvm_start |-> $past(ctl_q.wen));

    // R5: busy holds until done or warm reset
    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!por_n)
        ctl_q.go && !nvm_done && warm_rst_n |=> ctl_q.go);

    // R6: stall only while busy
    p_stall_busy_r6: assert property (@(posedge clk) disable iff (!por_n)
        cpu_stall |-> ctl_q.go);

    // R7: interrupted write leaves the error set
    p_err_on_abort_r7: assert property (@(posedge clk) disable iff (!por_n)
        ctl_q.go && !warm_rst_n |=> ctl_q.err);

    // R7: error survives warm reset
    p_err_keeps_r7: assert property (@(posedge clk) disable iff (!por_n)
        ctl_q.err && !warm_rst_n |=> ctl_q.err);

    // R10: completion flag is a single cycle
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!por_n)
        done_irq |=> !done_irq);
endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
    import nvm_guard_pkg::*;
#(
    parameter int               PTR_W = 22,
    parameter logic [BUS_W-1:0] KEY_A = 8'h55,
    parameter logic [BUS_W-1:0] KEY_B = 8'hAA
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              nvm_start,
    output logic              nvm_rd_start,
    output logic [1:0]        nvm_sel,
    output logic [PTR_W-1:0]  nvm_addr,
    input  logic              nvm_done,
    output logic              cpu_stall,
    output logic              done_irq
);
    logic             armed;
    logic [BUS_W-1:0] ctrl_byte;
    logic [BUS_W-1:0] ptr_byte;

    nvm_unlock_seq #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_seq (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .armed      (armed)
    );

    nvm_tblptr #(.PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .rd_byte    (ptr_byte),
        .ptr        (nvm_addr)
    );

    nvm_write_ctrl u_ctl (
        .clk          (clk),
        .por_n        (por_n),
        .warm_rst_n   (warm_rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .armed        (armed),
        .ptr_conf     (nvm_addr[PTR_W-1]),
        .nvm_done     (nvm_done),
        .ctrl_byte    (ctrl_byte),
        .nvm_start    (nvm_start),
        .nvm_rd_start (nvm_rd_start),
        .nvm_sel      (nvm_sel),
        .cpu_stall    (cpu_stall),
        .done_irq     (done_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == A_CTRL) bus_rdata = ctrl_byte;
            else                    bus_rdata = ptr_byte;
        end
    end

    // R1: the key register never returns data
    p_key_reads_zero_r1: assert property (@(posedge clk) disable iff (!por_n)
        bus_sel && !bus_we && bus_addr == A_KEY |-> bus_rdata == '0);
endmodule

// File: tb/nvm_write_guard_bench.sv
module nvm_write_guard_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        nvm_start, nvm_rd_start, cpu_stall, done_irq;
    logic [1:0]  nvm_sel;
    logic [21:0] nvm_addr;
    logic        nvm_done = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    nvm_write_guard u_nvm_write_guard (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nvm_start(nvm_start), .nvm_rd_start(nvm_rd_start),
        .nvm_sel(nvm_sel), .nvm_addr(nvm_addr), .nvm_done(nvm_done),
        .cpu_stall(cpu_stall), .done_irq(done_irq)
    );

    typedef struct packed {
        logic [2:0] a0; logic [7:0] d0;
        logic [2:0] a1; logic [7:0] d1;
        logic [2:0] a2; logic [7:0] d2;
        logic       go;
    } vec_t;

    // unlock patterns; WREN is set before each one
    localparam vec_t VECS [7] = '{
        '{3'd1, 8'h55, 3'd1, 8'hAA, 3'd0, 8'h03, 1'b1},
        '{3'd1, 8'hAA, 3'd1, 8'h55, 3'd0, 8'h03, 1'b0},
        '{3'd1, 8'h55, 3'd1, 8'h55, 3'd0, 8'h03, 1'b0},
        '{3'd1, 8'h55, 3'd2, 8'h00, 3'd0, 8'h03, 1'b0},
        '{3'd1, 8'h55, 3'd1, 8'hAA, 3'd1, 8'hAA, 1'b0},
        '{3'd1, 8'h55, 3'd1, 8'hAA, 3'd0, 8'h01, 1'b0},
        '{3'd0, 8'h03, 3'd1, 8'h55, 3'd1, 8'hAA, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic warm_pulse();
        @(negedge clk); warm_rst_n = 1'b0;
        @(negedge clk); warm_rst_n = 1'b1;
    endtask

    task automatic done_pulse();
        @(negedge clk); nvm_done = 1'b1;
        @(negedge clk); nvm_done = 1'b0;
    endtask

    task automatic unlock_go(input logic [7:0] ctrl);
        bus_wr(3'd1, 8'h55);
        bus_wr(3'd1, 8'hAA);
        bus_wr(3'd0, ctrl);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // reset state (R8)
        bus_rd(3'd0, rd); chk("R8 ctrl after por", rd, 8'h00);
        chk("R11 addr after por", nvm_addr, 0);
        chk("R6 stall after por", cpu_stall, 0);

        // vector walk (R2, R3)
        foreach (VECS[i]) begin
            bus_wr(3'd0, 8'h01);
            bus_wr(VECS[i].a0, VECS[i].d0);
            bus_wr(VECS[i].a1, VECS[i].d1);
            bus_wr(VECS[i].a2, VECS[i].d2);
            chk($sformatf("R2 R3 vector %0d start", i), nvm_start, VECS[i].go);
            if (VECS[i].go) done_pulse();
        end

        // R1 key register stores nothing
        bus_wr(3'd1, 8'h55);
        bus_rd(3'd1, rd); chk("R1 key reads zero", rd, 8'h00);
        bus_rd(3'd5, rd); chk("R12 unused address reads zero", rd, 8'h00);

        // R11 pointer bytes, R9 region from bit 21
        bus_wr(3'd2, 8'h12); bus_wr(3'd3, 8'h34); bus_wr(3'd4, 8'hFF);
        bus_rd(3'd4, rd); chk("R11 upper byte", rd, 8'h3F);
        bus_rd(3'd3, rd); chk("R11 high byte", rd, 8'h34);
        chk("R11 full pointer", nvm_addr, 22'h3F3412);
        chk("R9 bit21 selects config", nvm_sel, 2'b10);
        bus_wr(3'd4, 8'h00);
        bus_wr(3'd0, 8'h20); chk("R9 program select", nvm_sel, 2'b01);
        bus_wr(3'd0, 8'h30); chk("R9 cfg overrides", nvm_sel, 2'b10);
        bus_wr(3'd0, 8'h00); chk("R9 data select", nvm_sel, 2'b00);

        // R4 WREN set in the same write does not count
        unlock_go(8'h03);
        chk("R4 no start with wren clear", nvm_start, 0);
        bus_rd(3'd0, rd); chk("R4 WR stays clear", rd, 8'h01);

        // R3 a read between keys aborts
        bus_wr(3'd1, 8'h55); bus_rd(3'd0, rd); bus_wr(3'd1, 8'hAA); bus_wr(3'd0, 8'h03);
        chk("R3 read aborts sequence", nvm_start, 0);

        // R5 R6 R10 program write
        bus_wr(3'd0, 8'h21);
        unlock_go(8'h23);
        chk("R2 start pulse", nvm_start, 1);
        chk("R6 stall program", cpu_stall, 1);
        bus_wr(3'd0, 8'h21);
        bus_rd(3'd0, rd); chk("R5 WR held busy", rd, 8'h23);
        chk("R2 start single cycle", nvm_start, 0);
        done_pulse();
        chk("R10 irq on done", done_irq, 1);
        chk("R6 stall released", cpu_stall, 0);
        bus_rd(3'd0, rd); chk("R5 WR self clears", rd, 8'h21);
        chk("R10 irq single cycle", done_irq, 0);
        done_pulse();
        chk("R10 stray done no irq", done_irq, 0);

        // R6 data write does not stall
        bus_wr(3'd0, 8'h01);
        unlock_go(8'h03);
        chk("R6 data start", nvm_start, 1);
        chk("R6 data no stall", cpu_stall, 0);
        done_pulse();

        // R7 R8 warm reset mid-write
        bus_wr(3'd2, 8'h77);
        bus_wr(3'd0, 8'h21);
        unlock_go(8'h23);
        warm_pulse();
        chk("R10 no irq on abort", done_irq, 0);
        bus_rd(3'd0, rd); chk("R7 R8 err set others clear", rd, 8'h08);
        chk("R8 pointer cleared", nvm_addr, 0);
        chk("R6 stall dropped", cpu_stall, 0);
        warm_pulse();
        bus_rd(3'd0, rd); chk("R7 err survives warm", rd, 8'h08);
        bus_wr(3'd0, 8'h00);
        bus_rd(3'd0, rd); chk("R7 sw clear", rd, 8'h00);
        bus_wr(3'd0, 8'h08);
        bus_rd(3'd0, rd); chk("R7 sw cannot set", rd, 8'h00);

        // R7 por clears err
        bus_wr(3'd0, 8'h01);
        unlock_go(8'h03);
        warm_pulse();
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        bus_rd(3'd0, rd); chk("R7 por clears err", rd, 8'h00);

        // R12 read launch
        bus_wr(3'd0, 8'h04);
        chk("R12 read pulse", nvm_rd_start, 1);
        @(negedge clk);
        chk("R12 read pulse ends", nvm_rd_start, 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule